// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Read-During-Write Modes

A synchronous RAM with two ports, A and B, sharing one storage array on a common clock. Each port has its own enable, byte write enables, address, write data and read data. A parameter on each port picks what that port's read data shows when the same port writes in that cycle: the freshly merged word (write-first), the word held before the write (read-first), or the previous read data unchanged (no-change).

Either port can add an output pipeline register. This register has its own clock enable and a synchronous reset to a parameterised value. A per-port parameter decides whether the reset works on its own or only while the clock enable is high. When both ports write the same word in one cycle, port A wins on every byte lane that both enable. A port that reads a word the other port is writing gets the contents from before that cycle.

Top module: `tdp_ram`

## Requirements
- R1: A word written with all byte enables set is returned by a later read at the same address on either port. Read data appears one clock after the address is sampled when the port has no output register, and two clocks after when it has one.
- R2: Byte lane i is bits [8i+7:8i] of the data and is written only when write-enable bit i is set. Lanes whose bit is clear keep their stored contents.
- R3: In write-first mode, a write also updates the port's read data with the stored word after the byte merge.
- R4: In read-first mode, a write updates the port's read data with the word held before the write.
- R5: In no-change mode, the port's read data holds its previous value during a write.
- R6: With the port enable low, the port writes nothing and its read data holds, whatever the byte enables are.
- R7: With reset priority over the clock enable, a synchronous reset loads the output register with its reset value whatever the clock enable is.
- R8: With clock-enable priority, a synchronous reset acts only while the output register's clock enable is high. Otherwise the register holds.
- R9: The output register holds while its clock enable is low and no active reset applies.
- R10: When both ports write the same address in one cycle, each byte lane enabled on port A takes port A's data. Lanes enabled only on port B take port B's data.
- R11: A read on one port of an address the other port writes in the same cycle returns the contents from before that cycle.
- R12: While rst_ni is low, read data is zero on ports without an output register, and each output register holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous active-low reset of the read paths |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | DATA_W/BYTE_W | Port A byte write enables |
| a_addr_i | input | $clog2(DEPTH) | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_srst_i | input | 1 | Port A output register synchronous reset |
| a_regce_i | input | 1 | Port A output register clock enable |
| a_rdata_o | output | DATA_W | Port A read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | DATA_W/BYTE_W | Port B byte write enables |
| b_addr_i | input | $clog2(DEPTH) | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_srst_i | input | 1 | Port B output register synchronous reset |
| b_regce_i | input | 1 | Port B output register clock enable |
| b_rdata_o | output | DATA_W | Port B read data |

## Verification
The assertions assume that addresses stay below DEPTH and that inputs are stable around the rising edge. The collision check also assumes that any two addresses compared as equal refer to one stored word. The stimulus keeps within this: it drives inputs only on the falling edge and uses addresses from 0 to DEPTH-1 only. It fills every word through port A with all lanes enabled before any read, so no expected value depends on uninitialised storage. It then covers every pair of byte-enable patterns in same-address collisions.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic [1:0] {
    RDW_WRITE_FIRST = 2'd0,
    RDW_READ_FIRST  = 2'd1,
    RDW_NO_CHANGE   = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/tdp_ram_port.sv
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              BYTE_W      = 8,
  parameter rdw_mode_e       MODE        = RDW_WRITE_FIRST,
  parameter bit              OUT_REG     = 1'b0,
  parameter bit              RST_OVER_CE = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL   = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [DATA_W/BYTE_W-1:0] we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W-1:0]        rd_word_i,
  input  logic                     srst_i,
  input  logic                     regce_i,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int NB = DATA_W / BYTE_W;

  logic              wr;
  logic              load;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] rd_q;

  assign wr = en_i & (|we_i);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      merged[i*BYTE_W +: BYTE_W] = we_i[i] ? wdata_i[i*BYTE_W +: BYTE_W]
                                           : rd_word_i[i*BYTE_W +: BYTE_W];
    end
  end

  if (MODE == RDW_WRITE_FIRST) begin : g_wf
    assign load = en_i;
    assign nxt  = wr ? merged : rd_word_i;
  end else if (MODE == RDW_READ_FIRST) begin : g_rf
    assign load = en_i;
    assign nxt  = rd_word_i;
  end else begin : g_nc
    assign load = en_i & ~wr;
    assign nxt  = rd_word_i;
    // R5
    no_change_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr |=> $stable(rd_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (load) rd_q <= nxt;
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rd_q));

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] out_q;
    logic              do_rst;

    assign do_rst = srst_i & (RST_OVER_CE | regce_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q <= RST_VAL;
      else if (do_rst)  out_q <= RST_VAL;
      else if (regce_i) out_q <= rd_q;
    end
    assign rdata_o = out_q;

    // R9
    oreg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !regce_i && !srst_i |=> $stable(out_q));

    if (RST_OVER_CE) begin : g_rst_pri
      // R7
      srst_over_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> out_q == RST_VAL);
    end else begin : g_ce_pri
      // R8
      srst_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i && !regce_i |=> $stable(out_q));
      // R8
      srst_with_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i && regce_i |=> out_q == RST_VAL);
    end
  end else begin : g_noreg
    logic unused_w;
    assign unused_w = srst_i ^ regce_i;
    assign rdata_o  = rd_q;
  end
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdp_ram_pkg::*;
#(
  parameter int                DATA_W        = 32,
  parameter int                BYTE_W        = 8,
  parameter int                DEPTH         = 1024,
  parameter rdw_mode_e         MODE_A        = RDW_WRITE_FIRST,
  parameter rdw_mode_e         MODE_B        = RDW_READ_FIRST,
  parameter bit                OUT_REG_A     = 1'b1,
  parameter bit                OUT_REG_B     = 1'b0,
  parameter bit                RST_OVER_CE_A = 1'b1,
  parameter bit                RST_OVER_CE_B = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL_A     = '0,
  parameter logic [DATA_W-1:0] RST_VAL_B     = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       a_en_i,
  input  logic [DATA_W/BYTE_W-1:0]   a_we_i,
  input  logic [$clog2(DEPTH)-1:0]   a_addr_i,
  input  logic [DATA_W-1:0]          a_wdata_i,
  input  logic                       a_srst_i,
  input  logic                       a_regce_i,
  output logic [DATA_W-1:0]          a_rdata_o,
  input  logic                       b_en_i,
  input  logic [DATA_W/BYTE_W-1:0]   b_we_i,
  input  logic [$clog2(DEPTH)-1:0]   b_addr_i,
  input  logic [DATA_W-1:0]          b_wdata_i,
  input  logic                       b_srst_i,
  input  logic                       b_regce_i,
  output logic [DATA_W-1:0]          b_rdata_o
);
  localparam int NB = DATA_W / BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_word;
  logic [DATA_W-1:0] b_word;

  assign a_word = mem[a_addr_i];
  assign b_word = mem[b_addr_i];

  // Port B lanes first so that port A's later assignment wins a collision.
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NB; i++) begin
      if (b_en_i && b_we_i[i]) mem[b_addr_i][i*BYTE_W +: BYTE_W] <= b_wdata_i[i*BYTE_W +: BYTE_W];
      if (a_en_i && a_we_i[i]) mem[a_addr_i][i*BYTE_W +: BYTE_W] <= a_wdata_i[i*BYTE_W +: BYTE_W];
    end
  end

  tdp_ram_port #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .MODE(MODE_A), .OUT_REG(OUT_REG_A),
    .RST_OVER_CE(RST_OVER_CE_A), .RST_VAL(RST_VAL_A)
  ) u_port_a (
    .clk_i, .rst_ni, .en_i(a_en_i), .we_i(a_we_i), .wdata_i(a_wdata_i),
    .rd_word_i(a_word), .srst_i(a_srst_i), .regce_i(a_regce_i), .rdata_o(a_rdata_o)
  );

  tdp_ram_port #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .MODE(MODE_B), .OUT_REG(OUT_REG_B),
    .RST_OVER_CE(RST_OVER_CE_B), .RST_VAL(RST_VAL_B)
  ) u_port_b (
    .clk_i, .rst_ni, .en_i(b_en_i), .we_i(b_we_i), .wdata_i(b_wdata_i),
    .rd_word_i(b_word), .srst_i(b_srst_i), .regce_i(b_regce_i), .rdata_o(b_rdata_o)
  );

  // R10
  collide_a_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_en_i && b_en_i && (a_addr_i == b_addr_i) && (&a_we_i)
    |=> mem[$past(a_addr_i)] == $past(a_wdata_i));

  // R6
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_en_i && !b_en_i |=> mem[$past(a_addr_i)] == $past(a_word));
endmodule

// File: tb/tdp_ram_tb.sv
module tdp_ram_tb;
  import tdp_ram_pkg::*;

  localparam int DW = 16;
  localparam int BW = 8;
  localparam int DEPTH = 16;
  localparam logic [DW-1:0] RV1A = 16'hA5A5;
  localparam logic [DW-1:0] RV2B = 16'h5A5A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic          a_en, a_srst, a_regce, b_en, b_srst, b_regce;
  logic [1:0]    a_we, b_we;
  logic [3:0]    a_addr, b_addr;
  logic [DW-1:0] a_wd, b_wd;
  logic [DW-1:0] d1_a, d1_b, d2_a, d2_b;

  int errors = 0;
  int checks = 0;
  string tag = "";

  logic [DW-1:0] m [DEPTH];
  logic [DW-1:0] e1a_s1, e1a_or, e1b_s1, e2a_s1, e2b_s1, e2b_or;

  always #2 clk = ~clk;

  // dut1: A write-first + out reg (reset over CE), B read-first, no out reg
  tdp_ram #(
    .DATA_W(DW), .BYTE_W(BW), .DEPTH(DEPTH),
    .MODE_A(RDW_WRITE_FIRST), .MODE_B(RDW_READ_FIRST),
    .OUT_REG_A(1'b1), .OUT_REG_B(1'b0), .RST_OVER_CE_A(1'b1), .RST_OVER_CE_B(1'b1),
    .RST_VAL_A(RV1A), .RST_VAL_B('0)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_srst_i(a_srst), .a_regce_i(a_regce), .a_rdata_o(d1_a),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_srst_i(b_srst), .b_regce_i(b_regce), .b_rdata_o(d1_b)
  );

  // dut2: both no-change; B with out reg (CE priority)
  tdp_ram #(
    .DATA_W(DW), .BYTE_W(BW), .DEPTH(DEPTH),
    .MODE_A(RDW_NO_CHANGE), .MODE_B(RDW_NO_CHANGE),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .RST_OVER_CE_A(1'b1), .RST_OVER_CE_B(1'b0),
    .RST_VAL_A('0), .RST_VAL_B(RV2B)
  ) u_dut_nc (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_srst_i(a_srst), .a_regce_i(a_regce), .a_rdata_o(d2_a),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_srst_i(b_srst), .b_regce_i(b_regce), .b_rdata_o(d2_b)
  );

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] wd, logic [1:0] we);
    merge = old;
    if (we[0]) merge[7:0]  = wd[7:0];
    if (we[1]) merge[15:8] = wd[15:8];
  endfunction

  // mode: 0 write-first, 1 read-first, 2 no-change
  function automatic logic [DW-1:0] s1n(int mode, logic [DW-1:0] cur, logic [DW-1:0] old,
                                        logic [DW-1:0] mg, logic en, logic wr);
    if (!en) return cur;
    if (!wr) return old;
    case (mode)
      0:       return mg;
      1:       return old;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [DW-1:0] oa, ob, ma, mb;
    logic wa, wb;
    logic [DW-1:0] n1a, n1b, n2a, n2b, o1a, o2b;
    oa = m[a_addr]; ob = m[b_addr];
    ma = merge(oa, a_wd, a_we); mb = merge(ob, b_wd, b_we);
    wa = a_en && (|a_we); wb = b_en && (|b_we);
    n1a = s1n(0, e1a_s1, oa, ma, a_en, wa);
    n1b = s1n(1, e1b_s1, ob, mb, b_en, wb);
    n2a = s1n(2, e2a_s1, oa, ma, a_en, wa);
    n2b = s1n(2, e2b_s1, ob, mb, b_en, wb);
    o1a = a_srst ? RV1A : (a_regce ? e1a_s1 : e1a_or);
    o2b = (b_srst && b_regce) ? RV2B : (b_regce ? e2b_s1 : e2b_or);
    @(posedge clk);
    if (b_en && b_we[0]) m[b_addr][7:0]  = b_wd[7:0];
    if (b_en && b_we[1]) m[b_addr][15:8] = b_wd[15:8];
    if (a_en && a_we[0]) m[a_addr][7:0]  = a_wd[7:0];
    if (a_en && a_we[1]) m[a_addr][15:8] = a_wd[15:8];
    e1a_s1 = n1a; e1b_s1 = n1b; e2a_s1 = n2a; e2b_s1 = n2b;
    e1a_or = o1a; e2b_or = o2b;
    @(negedge clk);
    chk("dut1.a", d1_a, e1a_or);
    chk("dut1.b", d1_b, e1b_s1);
    chk("dut2.a", d2_a, e2a_s1);
    chk("dut2.b", d2_b, e2b_or);
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; a_srst = 0; a_regce = 1;
    b_en = 0; b_we = 0; b_srst = 0; b_regce = 1;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(); a_regce = 0; b_regce = 0;
    a_addr = 0; b_addr = 0; a_wd = 0; b_wd = 0;
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    e1a_s1 = '0; e1b_s1 = '0; e2a_s1 = '0; e2b_s1 = '0;
    e1a_or = RV1A; e2b_or = RV2B;
    repeat (3) @(negedge clk);
    tag = "R12 reset";
    chk("dut1.a", d1_a, RV1A); chk("dut1.b", d1_b, '0);
    chk("dut2.a", d2_a, '0);   chk("dut2.b", d2_b, RV2B);
    rst_ni = 1;
    @(negedge clk);

    // R1 R3 R5: fill through port A, full words
    tag = "R1 R3 R5 fill";
    idle();
    for (int i = 0; i < DEPTH; i++) begin
      a_en = 1; a_we = 2'b11; a_addr = 4'(i); a_wd = 16'h1000 + 16'(i) * 16'h0111;
      step();
    end
    // R1 R4: reads on both ports
    tag = "R1 R4 read";
    idle();
    for (int i = 0; i < DEPTH; i++) begin
      a_en = 1; a_addr = 4'(i); b_en = 1; b_addr = 4'(DEPTH - 1 - i);
      step();
    end
    // R2 R11: byte writes on A while B reads the same word
    tag = "R2 R11 byte";
    for (int i = 0; i < DEPTH; i++) begin
      idle();
      a_en = 1; a_we = 2'(1 + (i % 2)); a_addr = 4'(i); a_wd = 16'hC3C3 ^ 16'(i * 37);
      b_en = 1; b_addr = 4'(i);
      step();
      idle(); a_en = 1; a_addr = 4'(i); b_en = 1; b_addr = 4'(i);
      step();
    end
    // R4 R5 R6: writes on B, A disabled with stray byte enables
    tag = "R4 R5 R6 portb";
    for (int i = 0; i < DEPTH; i++) begin
      idle();
      b_en = 1; b_we = 2'b11; b_addr = 4'(i); b_wd = 16'h7E00 + 16'(i);
      a_en = 0; a_we = 2'b11; a_addr = 4'((i + 3) % DEPTH); a_wd = 16'hDEAD;
      step();
    end
    idle();
    for (int i = 0; i < DEPTH; i++) begin
      a_en = 1; a_addr = 4'(i); b_en = 1; b_addr = 4'(i); step();
    end
    // R10: every pair of byte-enable patterns on a same-address collision
    tag = "R10 collide";
    for (int wa = 0; wa < 4; wa++) begin
      for (int wb = 0; wb < 4; wb++) begin
        idle();
        a_en = 1; a_we = 2'(wa); a_addr = 4'(wa * 4 + wb); a_wd = 16'hAA00 + 16'(wa * 4 + wb);
        b_en = 1; b_we = 2'(wb); b_addr = 4'(wa * 4 + wb); b_wd = 16'h0055 + 16'(wb * 256);
        step();
        idle(); a_en = 1; a_addr = 4'(wa * 4 + wb); b_en = 1; b_addr = 4'(wa * 4 + wb);
        step(); step();
      end
    end
    // R7 R8 R9: output register reset and clock enable combinations
    tag = "R7 R8 R9 oreg";
    for (int k = 0; k < 16; k++) begin
      idle();
      a_en = 1; a_addr = 4'(k); b_en = 1; b_addr = 4'(15 - k);
      a_srst = k[0]; a_regce = k[1]; b_srst = k[2]; b_regce = k[3];
      step();
      idle(); a_regce = 0; b_regce = 0; a_en = 1; a_addr = 4'(k ^ 5);
      step();
      idle(); step();
    end
    idle();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule